// File: doc/BRIEF.md
# Rename history buffer with rollback

This block keeps an ordered record of every destination-register rename made by an out-of-order core's rename stage. Each record pairs an instruction sequence number with the architectural register it wrote, the physical register newly given to it, and the physical register that held the mapping before. The records are kept so that a rename can later be undone or made permanent. The map table and the free list sit outside the block. The block drives them through two plain write ports: a map-restore write of an architectural register and a physical register, and a free-register write of one physical register.

Three kinds of request start a walk over the stored records. A squash bounded by a sequence number walks back from the youngest record and undoes every record younger than the bound. A commit bounded by a sequence number walks forward from the oldest record and releases the previous register of every record at or below the bound. A flush undoes every record. A walk handles one record per cycle and holds `busy` high until it finishes. The rename port is back-pressured while a walk runs or the buffer is full.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0), `busy`=0, `ren_ready`=1, and neither `map_we` nor `free_we` is asserted.
- R2: A record is stored at the young end on a rising edge where `ren_valid`=1, `ren_ready`=1 and neither `sq_req` nor `flush_req` is high. `ren_ready` equals not `full` and not `busy`. `full` rises once DEPTH records are held, and a rename offered while `ren_ready`=0 is not stored.
- R3: A squash with bound S processes records youngest-first while their sequence number is greater than S. Each processed record gives one cycle with `map_we`=1 (`map_arch` = its architectural register, `map_phys` = its previous register) and `free_we`=1 (`free_phys` = its new register).
- R4: A commit with bound C processes records oldest-first while their sequence number is at most C. Each processed record gives one cycle with `free_we`=1 (`free_phys` = its previous register) and `map_we`=0.
- R5: A commit whose bound is below the oldest record's sequence number produces no write and removes no record.
- R6: A squash or commit on an empty buffer produces no write.
- R7: A commit request is ignored when a squash or flush is requested in the same cycle, and when a walk is already running.
- R8: A flush undoes every stored record, youngest-first, with the same writes as R3, and leaves the buffer empty.
- R9: `busy` rises in the cycle after an accepted request and stays high for one cycle per processed record plus one final cycle without writes. Renames are refused while `busy`=1.
- R10: Sequence numbers compare as plain unsigned values of SEQ_W bits, with no wrap-around handling.
- R11: A squash request arriving during a commit walk takes over at the next edge. The records retired before that edge stay retired, and the squash then walks from the youngest record that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename record offered |
| ren_seq | input | SEQ_W | Sequence number of the renaming instruction |
| ren_arch | input | ARCH_W | Architectural destination register |
| ren_new_phys | input | PHYS_W | Physical register newly allocated |
| ren_old_phys | input | PHYS_W | Physical register previously mapped |
| ren_ready | output | 1 | Record can be accepted this cycle |
| sq_req | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash bound: records above it are undone |
| cm_req | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Commit bound: records at or below it retire |
| flush_req | input | 1 | Undo all records |
| busy | output | 1 | A walk is in progress |
| empty | output | 1 | No record held |
| full | output | 1 | DEPTH records held |
| map_we | output | 1 | Map-restore write strobe |
| map_arch | output | ARCH_W | Architectural register to restore |
| map_phys | output | PHYS_W | Physical register restored into the map |
| free_we | output | 1 | Free-register write strobe |
| free_phys | output | PHYS_W | Physical register returned to the free list |

## Verification
A request is sampled on a rising edge, and the first record it processes shows up on the write ports during the cycle right after that edge. Each further record follows one cycle later, and `busy` then falls one cycle after the last write. The bench samples outputs on the falling edge. A scoreboard holds the writes that a bench-side copy of the record list predicts, in the order they are due. Each walk task also counts the `busy` cycles and expects that count to equal the number of processed records plus one. For the takeover and in-walk commit cases, the bench counts the edges between the requests by hand so that the expected split between retired and undone records is exact.

// File: rtl/rhb_pkg.sv
`timescale 1ns/1ps
package rhb_pkg;

   // Walk engine state
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_UNDO   = 2'd1,
      WK_RETIRE = 2'd2
   } walk_state_t;

endpackage

// File: rtl/rhb_store.sv
`timescale 1ns/1ps
// Circular record store: push at the young end, pop from either end.
module rhb_store #(
   parameter int DEPTH  = 8,
   parameter int SEQ_W  = 16,
   parameter int ARCH_W = 5,
   parameter int PHYS_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [SEQ_W-1:0]  push_seq,
   input  logic [ARCH_W-1:0] push_arch,
   input  logic [PHYS_W-1:0] push_new,
   input  logic [PHYS_W-1:0] push_prev,
   input  logic              pop_young,
   input  logic              pop_old,
   output logic              empty,
   output logic              full,
   output logic [SEQ_W-1:0]  young_seq,
   output logic [ARCH_W-1:0] young_arch,
   output logic [PHYS_W-1:0] young_new,
   output logic [PHYS_W-1:0] young_prev,
   output logic [SEQ_W-1:0]  old_seq,
   output logic [PHYS_W-1:0] old_prev
);

   localparam int  PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W    = $clog2(DEPTH + 1);
   localparam bit  IS_POW2  = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

   logic [SEQ_W-1:0]  seq_q  [DEPTH];
   logic [ARCH_W-1:0] arch_q [DEPTH];
   logic [PHYS_W-1:0] new_q  [DEPTH];
   logic [PHYS_W-1:0] prev_q [DEPTH];

   logic [PTR_W-1:0] head_q, tail_q;
   logic [PTR_W-1:0] head_nx, tail_nx, tail_pv;
   logic [CNT_W-1:0] count_q;

   // Pointer stepping: natural wrap for power-of-two depth, compare otherwise
   generate
      if (IS_POW2) begin : g_wrap_pow2
         always_comb begin
            head_nx = head_q + PTR_W'(1);
            tail_nx = tail_q + PTR_W'(1);
            tail_pv = tail_q - PTR_W'(1);
         end
      end else begin : g_wrap_cmp
         always_comb begin
            head_nx = (head_q == LAST_IDX) ? '0 : head_q + PTR_W'(1);
            tail_nx = (tail_q == LAST_IDX) ? '0 : tail_q + PTR_W'(1);
            tail_pv = (tail_q == '0) ? LAST_IDX : tail_q - PTR_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (push) begin
            tail_q  <= tail_nx;
            count_q <= count_q + CNT_W'(1);
         end else if (pop_young) begin
            tail_q  <= tail_pv;
            count_q <= count_q - CNT_W'(1);
         end else if (pop_old) begin
            head_q  <= head_nx;
            count_q <= count_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         seq_q[tail_q]  <= push_seq;
         arch_q[tail_q] <= push_arch;
         new_q[tail_q]  <= push_new;
         prev_q[tail_q] <= push_prev;
      end
   end

   assign empty      = (count_q == '0);
   assign full       = (count_q == CNT_MAX);
   assign young_seq  = seq_q[tail_pv];
   assign young_arch = arch_q[tail_pv];
   assign young_new  = new_q[tail_pv];
   assign young_prev = prev_q[tail_pv];
   assign old_seq    = seq_q[head_q];
   assign old_prev   = prev_q[head_q];

   // R2: a push never lands on a full store
   assert_push_has_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R2: a stored record is visible at the next cycle
   assert_push_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !empty);
   // R6: the walk engine never pops an empty store
   assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_young || pop_old) |-> !empty);
   // R9: pushes and pops never share a cycle
   assert_no_push_during_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_young || pop_old) |-> !push);

endmodule

// File: rtl/rhb_walker.sv
`timescale 1ns/1ps
// One-record-per-cycle walk engine for undo and retire.
module rhb_walker
   import rhb_pkg::*;
#(
   parameter int SEQ_W  = 16,
   parameter int ARCH_W = 5,
   parameter int PHYS_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sq_req,
   input  logic [SEQ_W-1:0]  sq_seq,
   input  logic              cm_req,
   input  logic [SEQ_W-1:0]  cm_seq,
   input  logic              flush_req,
   input  logic              empty,
   input  logic [SEQ_W-1:0]  young_seq,
   input  logic [ARCH_W-1:0] young_arch,
   input  logic [PHYS_W-1:0] young_new,
   input  logic [PHYS_W-1:0] young_prev,
   input  logic [SEQ_W-1:0]  old_seq,
   input  logic [PHYS_W-1:0] old_prev,
   output logic              pop_young,
   output logic              pop_old,
   output logic              busy,
   output logic              map_we,
   output logic [ARCH_W-1:0] map_arch,
   output logic [PHYS_W-1:0] map_phys,
   output logic              free_we,
   output logic [PHYS_W-1:0] free_phys
);

   walk_state_t      state_q, state_d;
   logic [SEQ_W-1:0] bound_q, bound_d;
   logic             all_q, all_d;
   logic             undo_hit, retire_hit;

   // Unsigned bound checks on the record at the active end
   always_comb begin
      undo_hit   = (state_q == WK_UNDO) && !empty &&
                   (all_q || (young_seq > bound_q));
      retire_hit = (state_q == WK_RETIRE) && !empty &&
                   (old_seq <= bound_q);
   end

   always_comb begin
      state_d = state_q;
      bound_d = bound_q;
      all_d   = all_q;
      if (flush_req) begin
         state_d = WK_UNDO;
         all_d   = 1'b1;
      end else if (sq_req) begin
         state_d = WK_UNDO;
         bound_d = sq_seq;
         all_d   = 1'b0;
      end else begin
         unique case (state_q)
            WK_IDLE: begin
               if (cm_req) begin
                  state_d = WK_RETIRE;
                  bound_d = cm_seq;
                  all_d   = 1'b0;
               end
            end
            WK_UNDO:   if (!undo_hit)   state_d = WK_IDLE;
            WK_RETIRE: if (!retire_hit) state_d = WK_IDLE;
            default:   state_d = WK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         bound_q <= '0;
         all_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         bound_q <= bound_d;
         all_q   <= all_d;
      end
   end

   assign busy      = (state_q != WK_IDLE);
   assign pop_young = undo_hit;
   assign pop_old   = retire_hit;
   assign map_we    = undo_hit;
   assign map_arch  = young_arch;
   assign map_phys  = young_prev;
   assign free_we   = undo_hit || retire_hit;
   assign free_phys = undo_hit ? young_new : old_prev;

   // R1: no write leaves the block while it is idle
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!map_we && !free_we));
   // R7: a squash request is never followed by a retire walk
   assert_no_retire_after_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_req || flush_req) |=> (state_q != WK_RETIRE));
   // R9: an accepted request makes the engine busy on the next cycle
   assert_busy_after_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_req || flush_req || (cm_req && !busy)) |=> busy);
   // R3: an undo write pairs a restore with a release
   assert_restore_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |-> free_we);

endmodule

// File: rtl/rename_history_buf.sv
`timescale 1ns/1ps
module rename_history_buf #(
   parameter int DEPTH  = 8,
   parameter int SEQ_W  = 16,
   parameter int ARCH_W = 5,
   parameter int PHYS_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren_valid,
   input  logic [SEQ_W-1:0]  ren_seq,
   input  logic [ARCH_W-1:0] ren_arch,
   input  logic [PHYS_W-1:0] ren_new_phys,
   input  logic [PHYS_W-1:0] ren_old_phys,
   output logic              ren_ready,
   input  logic              sq_req,
   input  logic [SEQ_W-1:0]  sq_seq,
   input  logic              cm_req,
   input  logic [SEQ_W-1:0]  cm_seq,
   input  logic              flush_req,
   output logic              busy,
   output logic              empty,
   output logic              full,
   output logic              map_we,
   output logic [ARCH_W-1:0] map_arch,
   output logic [PHYS_W-1:0] map_phys,
   output logic              free_we,
   output logic [PHYS_W-1:0] free_phys
);

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rename_history_buf: DEPTH must be at least 2");
      end
      if (SEQ_W < 2 || ARCH_W < 1 || PHYS_W < 1) begin : g_bad_width
         $error("rename_history_buf: field widths out of range");
      end
   endgenerate

   logic              push;
   logic              pop_young, pop_old;
   logic [SEQ_W-1:0]  young_seq, old_seq;
   logic [ARCH_W-1:0] young_arch;
   logic [PHYS_W-1:0] young_new, young_prev, old_prev;

   assign ren_ready = !full && !busy;
   assign push      = ren_valid && ren_ready && !sq_req && !flush_req;

   rhb_store #(
      .DEPTH (DEPTH),
      .SEQ_W (SEQ_W),
      .ARCH_W(ARCH_W),
      .PHYS_W(PHYS_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_seq  (ren_seq),
      .push_arch (ren_arch),
      .push_new  (ren_new_phys),
      .push_prev (ren_old_phys),
      .pop_young (pop_young),
      .pop_old   (pop_old),
      .empty     (empty),
      .full      (full),
      .young_seq (young_seq),
      .young_arch(young_arch),
      .young_new (young_new),
      .young_prev(young_prev),
      .old_seq   (old_seq),
      .old_prev  (old_prev)
   );

   rhb_walker #(
      .SEQ_W (SEQ_W),
      .ARCH_W(ARCH_W),
      .PHYS_W(PHYS_W)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .sq_req    (sq_req),
      .sq_seq    (sq_seq),
      .cm_req    (cm_req),
      .cm_seq    (cm_seq),
      .flush_req (flush_req),
      .empty     (empty),
      .young_seq (young_seq),
      .young_arch(young_arch),
      .young_new (young_new),
      .young_prev(young_prev),
      .old_seq   (old_seq),
      .old_prev  (old_prev),
      .pop_young (pop_young),
      .pop_old   (pop_old),
      .busy      (busy),
      .map_we    (map_we),
      .map_arch  (map_arch),
      .map_phys  (map_phys),
      .free_we   (free_we),
      .free_phys (free_phys)
   );

   // R9: renames are never stored while a walk runs
   assert_no_rename_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !busy);
   // R2: a full buffer refuses renames
   assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !ren_ready);

endmodule

// File: tb/rename_history_buf_bench.sv
`timescale 1ns/1ps
module rename_history_buf_bench;
   localparam int DEPTH  = 8;
   localparam int SEQ_W  = 16;
   localparam int ARCH_W = 5;
   localparam int PHYS_W = 7;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic              rst_n;
   logic              ren_valid;
   logic [SEQ_W-1:0]  ren_seq;
   logic [ARCH_W-1:0] ren_arch;
   logic [PHYS_W-1:0] ren_new_phys, ren_old_phys;
   logic              ren_ready;
   logic              sq_req, cm_req, flush_req;
   logic [SEQ_W-1:0]  sq_seq, cm_seq;
   logic              busy, empty, full;
   logic              map_we, free_we;
   logic [ARCH_W-1:0] map_arch;
   logic [PHYS_W-1:0] map_phys, free_phys;

   rename_history_buf #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
   ) u_rename_history_buf (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_seq(ren_seq), .ren_arch(ren_arch),
      .ren_new_phys(ren_new_phys), .ren_old_phys(ren_old_phys),
      .ren_ready(ren_ready),
      .sq_req(sq_req), .sq_seq(sq_seq), .cm_req(cm_req), .cm_seq(cm_seq),
      .flush_req(flush_req),
      .busy(busy), .empty(empty), .full(full),
      .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
      .free_we(free_we), .free_phys(free_phys)
   );

   typedef struct packed {
      logic [SEQ_W-1:0]  seq;
      logic [ARCH_W-1:0] arch;
      logic [PHYS_W-1:0] nw;
      logic [PHYS_W-1:0] pv;
   } rec_t;

   typedef struct packed {
      logic              m;
      logic [ARCH_W-1:0] arch;
      logic [PHYS_W-1:0] mp;
      logic [PHYS_W-1:0] fp;
   } exp_t;

   rec_t  model[$];     // index 0 = oldest
   exp_t  expq[$];
   string tagq[$];
   int    checks = 0;
   int    fails  = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // Monitor: compares every write against the scoreboard at the falling edge
   always @(negedge clk) begin
      if (rst_n && (map_we || free_we)) begin
         if (expq.size() == 0) begin
            check(1'b0, "R3/R4/R5/R6/R7", "unexpected write free_phys", int'(free_phys), -1);
         end else begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(map_we == e.m, t, "map_we", int'(map_we), int'(e.m));
            check(free_we == 1'b1, t, "free_we", int'(free_we), 1);
            if (e.m) begin
               check(map_arch == e.arch, t, "map_arch", int'(map_arch), int'(e.arch));
               check(map_phys == e.mp, t, "map_phys", int'(map_phys), int'(e.mp));
            end
            check(free_phys == e.fp, t, "free_phys", int'(free_phys), int'(e.fp));
         end
      end
   end

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic rename(input int seq, input int arch, input int nw, input int pv,
                         input bit expect_ok);
      rec_t r;
      ren_valid    = 1'b1;
      ren_seq      = SEQ_W'(seq);
      ren_arch     = ARCH_W'(arch);
      ren_new_phys = PHYS_W'(nw);
      ren_old_phys = PHYS_W'(pv);
      check(ren_ready == expect_ok, "R2", "ren_ready", int'(ren_ready), int'(expect_ok));
      step();
      ren_valid = 1'b0;
      if (expect_ok) begin
         r.seq = SEQ_W'(seq); r.arch = ARCH_W'(arch);
         r.nw = PHYS_W'(nw);  r.pv = PHYS_W'(pv);
         model.push_back(r);
      end
   endtask

   // Expected undo writes for bound s (all when every_rec is set)
   function automatic int plan_undo(input int s, input bit every_rec, input string tag);
      int n = 0;
      while (model.size() > 0 && (every_rec || model[model.size()-1].seq > SEQ_W'(s))) begin
         rec_t  r;
         exp_t  e;
         r = model.pop_back();
         e.m = 1'b1; e.arch = r.arch; e.mp = r.pv; e.fp = r.nw;
         expq.push_back(e);
         tagq.push_back(tag);
         n++;
      end
      return n;
   endfunction

   function automatic int plan_retire(input int c, input int limit, input string tag);
      int n = 0;
      while (model.size() > 0 && model[0].seq <= SEQ_W'(c) && n < limit) begin
         rec_t  r;
         exp_t  e;
         r = model.pop_front();
         e.m = 1'b0; e.arch = '0; e.mp = '0; e.fp = r.pv;
         expq.push_back(e);
         tagq.push_back(tag);
         n++;
      end
      return n;
   endfunction

   // Counts busy cycles from the next falling edge; ends in the drive phase
   task automatic wait_idle(input int exp_cycles, input string tag);
      int n = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!busy) break;
         n++;
      end
      check(n == exp_cycles, tag, "busy cycles", n, exp_cycles);
      check(expq.size() == 0, tag, "writes still pending", expq.size(), 0);
      step();
   endtask

   task automatic squash(input int s, input string tag);
      int n;
      n = plan_undo(s, 1'b0, tag);
      sq_req = 1'b1; sq_seq = SEQ_W'(s);
      step();
      sq_req = 1'b0;
      wait_idle(n + 1, tag);
   endtask

   task automatic commit(input int c, input string tag);
      int n;
      n = plan_retire(c, 1000, tag);
      cm_req = 1'b1; cm_seq = SEQ_W'(c);
      step();
      cm_req = 1'b0;
      wait_idle(n + 1, tag);
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0;
      ren_valid = 1'b0; ren_seq = '0; ren_arch = '0; ren_new_phys = '0; ren_old_phys = '0;
      sq_req = 1'b0; sq_seq = '0; cm_req = 1'b0; cm_seq = '0; flush_req = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();

      // R1: reset state
      check(empty == 1'b1, "R1", "empty", int'(empty), 1);
      check(full == 1'b0, "R1", "full", int'(full), 0);
      check(busy == 1'b0, "R1", "busy", int'(busy), 0);
      check(ren_ready == 1'b1, "R1", "ren_ready", int'(ren_ready), 1);
      check(!map_we && !free_we, "R1", "write strobes", int'(map_we | free_we), 0);

      // R6: requests on an empty buffer
      squash(0, "R6");
      commit(100, "R6");

      // R2: fill five records
      for (int i = 0; i < 5; i++) rename(10 + i, i, 20 + i, 40 + i, 1'b1);
      check(empty == 1'b0, "R2", "empty", int'(empty), 0);

      // R4: retire up to 11
      commit(11, "R4");
      // R5: bound below oldest (12) is ignored
      commit(5, "R5");
      // R3: undo records above 12
      squash(12, "R3");

      // R10: unsigned comparison of a large sequence number
      rename(16'hFFF0, 7, 60, 61, 1'b1);
      squash(100, "R10");
      commit(16'hFFFF, "R10");
      check(empty == 1'b1, "R10", "empty", int'(empty), 1);

      // R2: full back-pressure
      for (int i = 0; i < DEPTH; i++) rename(30 + i, i + 8, 70 + i, 90 + i, 1'b1);
      check(full == 1'b1, "R2", "full", int'(full), 1);
      rename(38, 3, 5, 6, 1'b0);

      // R7: commit with a squash in the same cycle is ignored
      n = plan_undo(35, 1'b0, "R7");
      sq_req = 1'b1; sq_seq = 16'd35; cm_req = 1'b1; cm_seq = 16'd37;
      step();
      sq_req = 1'b0; cm_req = 1'b0;
      wait_idle(n + 1, "R7");

      // R7/R9: commit during a squash walk is ignored; renames refused
      n = plan_undo(31, 1'b0, "R7");
      sq_req = 1'b1; sq_seq = 16'd31;
      step();
      sq_req = 1'b0;
      cm_req = 1'b1; cm_seq = 16'd40;
      check(ren_ready == 1'b0, "R9", "ren_ready while busy", int'(ren_ready), 0);
      step();
      cm_req = 1'b0;
      wait_idle(n, "R7");
      // Records 30 and 31 survived: retire them now
      commit(40, "R7");
      check(empty == 1'b1, "R7", "empty", int'(empty), 1);

      // R11: squash takes over a running commit walk after two retires
      for (int i = 0; i < 6; i++) rename(40 + i, i, 10 + i, 100 + i, 1'b1);
      void'(plan_retire(44, 2, "R11"));
      n = plan_undo(41, 1'b0, "R11");
      cm_req = 1'b1; cm_seq = 16'd44;
      step();
      cm_req = 1'b0;
      step();
      sq_req = 1'b1; sq_seq = 16'd41;
      step();
      sq_req = 1'b0;
      wait_idle(n + 1, "R11");
      check(empty == 1'b1, "R11", "empty", int'(empty), 1);

      // R8: flush undoes everything
      for (int i = 0; i < 4; i++) rename(50 + i, 20 + i, 30 + i, 80 + i, 1'b1);
      n = plan_undo(0, 1'b1, "R8");
      flush_req = 1'b1;
      step();
      flush_req = 1'b0;
      wait_idle(n + 1, "R8");
      check(empty == 1'b1, "R8", "empty", int'(empty), 1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule